// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

A first-in first-out buffer with separate write and read clocks. The two clocks may be tied together or may run with no relation to each other. Words enter on write-clock edges while the active-low write enable is low. Words leave into a registered output on read-clock edges while the active-low read enable is low. Five active-low status outputs report the fill state: Empty and Almost-Empty are produced in the read-clock domain, and Full, Almost-Full and Half-Full are produced in the write-clock domain. Each domain sees the other domain's pointer through a Gray-coded two-stage synchroniser. Because of this, a flag deasserts a little late and never too early.

The two almost thresholds are held in two offset registers that can be written and read at run time. No extra port is needed for them. While the active-low load strobe is low, a write-enabled write-clock edge stores bits [11:0] of the write data into an offset register instead of the buffer. A read-enabled read-clock edge while the strobe is low returns an offset register on the output instead of popping a word. Both accesses step through the empty offset first, then the full offset, and then back to the empty offset.

Top module: `prog_flag_fifo`

## Requirements
- R1: While rst_n is low at a clock edge, that domain's pointer returns to zero. After reset, empty_n=0, aempty_n=0, full_n=1, afull_n=1, half_n=1 and rdata=0.
- R2: A write-clock edge with wr_en_n=0 and load_n=1 stores wdata only while full_n=1. When full_n=0 the write is ignored and no stored word changes.
- R3: full_n is 0 exactly when the write domain counts 2^ADDR_W stored words. It falls right after the write-clock edge that stores the last free slot.
- R4: A read-clock edge with rd_en_n=0, load_n=1 and empty_n=1 loads the oldest word into rdata, so words leave in the order they were stored. With empty_n=0 the edge leaves rdata unchanged.
- R5: empty_n is 0 exactly when the read domain counts zero words. With coincident clocks, a write into an empty buffer raises empty_n after the second clock edge that follows the write edge.
- R6: aempty_n is 0 when the read-domain word count is at or below the empty offset.
- R7: afull_n is 0 when the free space counted in the write domain is at or below the full offset.
- R8: half_n is 0 when the write-domain word count exceeds 2^(ADDR_W-1).
- R9: After reset both offsets are 31 for ADDR_W<=8, 63 for ADDR_W=9 and 127 for ADDR_W>=10.
- R10: A write-clock edge with load_n=0 and wr_en_n=0 copies wdata[11:0] into an offset register and does not touch the buffer. The target alternates empty offset, full offset, empty offset, and so on, and reset returns the next target to the empty offset.
- R11: A read-clock edge with load_n=0 and rd_en_n=0 places an offset register in rdata[11:0], with zeros above bit 11, and does not pop the buffer. The readback alternates empty offset then full offset, and reset restarts it at the empty offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| load_n | input | 1 | Active-low offset access strobe |
| wdata | input | DATA_W | Write data, low 12 bits also carry offsets |
| rdata | output | DATA_W | Registered read data or offset readback |
| empty_n | output | 1 | Empty, active low, read domain |
| aempty_n | output | 1 | Almost-empty, active low, read domain |
| half_n | output | 1 | More than half full, active low, write domain |
| afull_n | output | 1 | Almost-full, active low, write domain |
| full_n | output | 1 | Full, active low, write domain |

## Verification
The assertions assume that rst_n is held low for several edges of both clocks, so that both pointers and both synchronisers clear together. They also assume that offset writes and offset readback do not overlap in time with the other clock's use of those registers. The stimulus meets these assumptions in two ways. It resets for eight edges of each clock whenever the clock relation changes. It performs all offset loads and readbacks only in the coincident-clock phase, with the buffer idle. The unrelated-clock phases then toggle only the data enables at random, against a queue model.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;

    typedef struct packed {
        logic full;
        logic afull;
        logic half;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic aempty;
    } rd_flags_t;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    function automatic ofs_sel_e sel_next(ofs_sel_e s);
        return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

    // threshold loaded into both offset registers at reset
    function automatic int default_ofs(int aw);
        if (aw <= 8) return 31;
        if (aw == 9) return 63;
        return 127;
    endfunction

endpackage

// File: rtl/pff_ptr_sync.sv
`timescale 1ns/1ps
module pff_ptr_sync #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    always_comb begin
        for (int i = 0; i < PW; i++)
            bin_out[i] = ^(stage2 >> i);
    end
endmodule

// File: rtl/pff_ram.sv
`timescale 1ns/1ps
module pff_ram #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pff_wr_ctl.sv
`timescale 1ns/1ps
module pff_wr_ctl
    import pff_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int OFS_W   = 12,
    parameter int DEF_OFS = 127,
    localparam int PW     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              load_n,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic [PW-1:0]     rptr_sync,
    output logic [PW-1:0]     wptr_gray,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output wr_flags_t         flags
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CMP_W = (OFS_W > PW) ? OFS_W : PW;

    logic [PW-1:0] wptr, wptr_nx, count, free;
    ofs_sel_e      sel;
    logic          load_hit;

    assign push     = !wr_en_n && load_n && !flags.full;
    assign load_hit = !wr_en_n && !load_n;
    assign wptr_nx  = wptr + PW'(push);
    assign waddr    = wptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            wptr_gray <= '0;
        end else begin
            wptr      <= wptr_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_ofs <= OFS_W'(DEF_OFS);
            full_ofs  <= OFS_W'(DEF_OFS);
            sel       <= SEL_EMPTY;
        end else if (load_hit) begin
            if (sel == SEL_EMPTY) empty_ofs <= ofs_in;
            else                  full_ofs  <= ofs_in;
            sel <= sel_next(sel);
        end
    end

    assign count = wptr - rptr_sync;
    assign free  = PW'(DEPTH) - count;

    always_comb begin
        flags.full  = (count == PW'(DEPTH));
        flags.afull = (CMP_W'(free) <= CMP_W'(full_ofs));
        flags.half  = (count > PW'(DEPTH / 2));
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));
    a_r2_blocked_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.full && !wr_en_n) |=> $stable(wptr));
    a_r10_load_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !wr_en_n) |=> $stable(wptr));
    a_r5_wr_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wptr_gray ^ $past(wptr_gray)));
    a_r8_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        flags.full |-> (flags.half && flags.afull));
endmodule

// File: rtl/pff_rd_ctl.sv
`timescale 1ns/1ps
module pff_rd_ctl
    import pff_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 12,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              load_n,
    input  logic [PW-1:0]     wptr_sync,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    input  logic [DATA_W-1:0] mem_q,
    output logic [PW-1:0]     rptr_gray,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output rd_flags_t         flags
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CMP_W = (OFS_W > PW) ? OFS_W : PW;

    logic [PW-1:0] rptr, rptr_nx, count;
    ofs_sel_e      sel;
    logic          take, peek;

    assign take    = !rd_en_n && load_n && !flags.empty;
    assign peek    = !rd_en_n && !load_n;
    assign rptr_nx = rptr + PW'(take);
    assign raddr   = rptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr      <= '0;
            rptr_gray <= '0;
        end else begin
            rptr      <= rptr_nx;
            rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            sel   <= SEL_EMPTY;
        end else if (take) begin
            rdata <= mem_q;
        end else if (peek) begin
            rdata <= DATA_W'((sel == SEL_EMPTY) ? empty_ofs : full_ofs);
            sel   <= sel_next(sel);
        end
    end

    assign count = wptr_sync - rptr;

    always_comb begin
        flags.empty  = (count == '0);
        flags.aempty = (CMP_W'(count) <= CMP_W'(empty_ofs));
    end

    a_r4_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.empty && !rd_en_n && load_n) |=> $stable(rdata));
    a_r11_peek_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !rd_en_n) |=> $stable(rptr));
    a_r6_empty_implies_aempty: assert property (@(posedge clk) disable iff (!rst_n)
        flags.empty |-> flags.aempty);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));
    a_r5_rd_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rptr_gray ^ $past(rptr_gray)));
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 12
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              load_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              half_n,
    output logic              afull_n,
    output logic              full_n
);
    localparam int PW      = ADDR_W + 1;
    localparam int DEF_OFS = default_ofs(ADDR_W);

    logic [PW-1:0]     wgray, rgray, wptr_sync, rptr_sync;
    logic              push;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_q;
    logic [OFS_W-1:0]  empty_ofs, full_ofs;
    wr_flags_t         wf;
    rd_flags_t         rf;

    pff_wr_ctl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) wr_i (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
        .ofs_in(wdata[OFS_W-1:0]), .rptr_sync(rptr_sync), .wptr_gray(wgray),
        .push(push), .waddr(waddr), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .flags(wf)
    );

    pff_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_q)
    );

    pff_ptr_sync #(.PW(PW)) w2r_i (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_sync)
    );

    pff_ptr_sync #(.PW(PW)) r2w_i (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_sync)
    );

    pff_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) rd_i (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .load_n(load_n),
        .wptr_sync(wptr_sync), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .mem_q(mem_q), .rptr_gray(rgray), .raddr(raddr), .rdata(rdata),
        .flags(rf)
    );

    assign full_n   = !wf.full;
    assign afull_n  = !wf.afull;
    assign half_n   = !wf.half;
    assign empty_n  = !rf.empty;
    assign aempty_n = !rf.aempty;
endmodule

// File: tb/prog_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb_top;
    localparam int DW = 18, AW = 8, OW = 12, DEPTH = 256, DEF = 31;

    logic wclk = 0, aclk = 0, async_mode = 0, rclk;
    real  ahalf = 3.5;
    always #2 wclk = ~wclk;
    always #(ahalf) aclk = ~aclk;
    assign rclk = async_mode ? aclk : wclk;

    logic rst_n = 0, wr_en_n = 1, rd_en_n = 1, load_n = 1;
    logic [DW-1:0] wdata = '0, rdata;
    logic empty_n, aempty_n, half_n, afull_n, full_n;

    prog_flag_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFS_W(OW)) dut_i (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .rd_en_n(rd_en_n), .load_n(load_n), .wdata(wdata), .rdata(rdata),
        .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    int checks = 0, errors = 0;
    logic [DW-1:0] q[$];
    logic [OW-1:0] m_eofs, m_fofs;
    bit m_wsel, m_rsel;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        q.delete();
        m_eofs = OW'(DEF); m_fofs = OW'(DEF); m_wsel = 0; m_rsel = 0;
    endtask

    task automatic do_reset(bit amode, real ah);
        rst_n = 0; wr_en_n = 1; rd_en_n = 1; load_n = 1;
        async_mode = amode; ahalf = ah;
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge aclk);
        @(negedge wclk);
        rst_n = 1;
        model_reset();
    endtask

    // coincident-clock step: drive at a falling edge, observe at the next one
    task automatic step(bit wen, bit ren, bit ld, logic [DW-1:0] d);
        bit do_pop = 0, do_peek = 0, do_hold = 0;
        logic [DW-1:0] exp = '0;
        wr_en_n = !wen; rd_en_n = !ren; load_n = !ld; wdata = d;
        if (ren && ld) begin
            exp = DW'(m_rsel ? m_fofs : m_eofs); m_rsel = !m_rsel; do_peek = 1;
        end else if (ren && empty_n && q.size() > 0) begin
            exp = q.pop_front(); do_pop = 1;
        end else if (ren) begin
            exp = rdata; do_hold = 1;
        end
        if (wen && ld) begin
            if (!m_wsel) m_eofs = d[OW-1:0]; else m_fofs = d[OW-1:0];
            m_wsel = !m_wsel;
        end else if (wen && full_n) q.push_back(d);
        @(negedge wclk);
        wr_en_n = 1; rd_en_n = 1; load_n = 1;
        if (do_peek) check("R9 R11 offset readback", 32'(rdata), 32'(exp));
        if (do_pop)  check("R2 R4 data order", 32'(rdata), 32'(exp));
        if (do_hold) check("R4 hold when empty", 32'(rdata), 32'(exp));
    endtask

    task automatic fill_drain();
        repeat (4) step(0, 0, 0, '0);
        for (int n = 1; n <= DEPTH; n++) begin
            step(1, 0, 0, DW'($urandom));
            check("R3 full", 32'(full_n), 32'(n != DEPTH));
            check("R7 almost full", 32'(afull_n), 32'(!((DEPTH - n) <= int'(m_fofs))));
            check("R8 half full", 32'(half_n), 32'(!(n > DEPTH / 2)));
        end
        step(1, 0, 0, 18'h3ffff);
        check("R2 write ignored when full", 32'(q.size()), 32'(DEPTH));
        check("R2 full stays", 32'(full_n), 32'(0));
        repeat (3) step(0, 0, 0, '0);
        check("R5 not empty", 32'(empty_n), 32'(1));
        check("R6 almost empty at full", 32'(aempty_n), 32'(!(DEPTH <= int'(m_eofs))));
        for (int m = 1; m <= DEPTH; m++) begin
            step(0, 1, 0, '0);
            check("R5 empty", 32'(empty_n), 32'(m != DEPTH));
            check("R6 almost empty", 32'(aempty_n), 32'(!((DEPTH - m) <= int'(m_eofs))));
        end
        step(0, 1, 0, '0);
    endtask

    task automatic writer(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en_n = ($urandom % 2) == 0;
            wdata = DW'($urandom);
            if (!wr_en_n && full_n) q.push_back(wdata);
        end
        @(negedge wclk);
        wr_en_n = 1;
    endtask

    task automatic reader(int n, int pct);
        bit pend = 0;
        logic [DW-1:0] pexp = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            if (pend) check("R4 data order async", 32'(rdata), 32'(pexp));
            pend = 0;
            rd_en_n = !(int'($urandom % 100) < pct);
            if (!rd_en_n && empty_n && q.size() > 0) begin
                pexp = q.pop_front(); pend = 1;
            end
        end
        @(negedge rclk);
        rd_en_n = 1;
        if (pend) check("R4 data order async", 32'(rdata), 32'(pexp));
    endtask

    task automatic rand_run(int n);
        fork
            writer(n);
            reader(n, 50);
        join
        repeat (6) @(negedge rclk);
        reader(q.size() * 2 + 16, 100);
        check("R4 all words delivered", 32'(q.size()), 32'(0));
        repeat (4) @(negedge rclk);
        check("R5 empty after drain", 32'(empty_n), 32'(0));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset(0, 3.5);

        check("R1 empty_n", 32'(empty_n), 32'(0));
        check("R1 aempty_n", 32'(aempty_n), 32'(0));
        check("R1 full_n", 32'(full_n), 32'(1));
        check("R1 afull_n", 32'(afull_n), 32'(1));
        check("R1 half_n", 32'(half_n), 32'(1));
        check("R1 rdata", 32'(rdata), 32'(0));

        step(0, 1, 1, '0);
        step(0, 1, 1, '0);
        check("R11 readback does not pop", 32'(empty_n), 32'(0));

        // R5 latency with coincident clocks
        repeat (2) step(0, 0, 0, '0);
        step(1, 0, 0, 18'h2a5a5);
        check("R5 empty after write edge", 32'(empty_n), 32'(0));
        step(0, 0, 0, '0);
        check("R5 empty one edge later", 32'(empty_n), 32'(0));
        step(0, 0, 0, '0);
        check("R5 not empty two edges later", 32'(empty_n), 32'(1));
        step(0, 1, 0, '0);
        check("R5 empty after last read", 32'(empty_n), 32'(0));
        step(0, 1, 0, '0);

        fill_drain();

        // R10 load new offsets, buffer untouched
        step(1, 0, 1, 18'h3f005);
        step(1, 0, 1, 18'h0000a);
        step(0, 0, 1, 18'h00063);
        repeat (3) step(0, 0, 0, '0);
        check("R10 load leaves buffer empty", 32'(empty_n), 32'(0));
        check("R10 load leaves full clear", 32'(full_n), 32'(1));
        step(0, 1, 1, '0);
        step(0, 1, 1, '0);
        fill_drain();

        // R10 sequence wraps: empty, full, empty
        step(1, 0, 1, 18'd7);
        step(1, 0, 1, 18'd9);
        step(1, 0, 1, 18'd11);
        check("R10 wrap target", 32'(m_eofs), 32'(11));
        step(0, 1, 1, '0);
        step(0, 1, 1, '0);

        // R10 reset restarts the sequence at the empty offset
        do_reset(0, 3.5);
        step(1, 0, 1, 18'd20);
        check("R10 reset restarts at empty", 32'(m_fofs), 32'(DEF));
        step(0, 1, 1, '0);
        step(0, 1, 1, '0);

        rand_run(1000);
        do_reset(1, 3.5);
        rand_run(2000);
        do_reset(1, 1.5);
        rand_run(2000);

        summary();
        $finish;
    end
endmodule